// File: doc/BRIEF.md
# Vector Lane Rotate-and-Insert Unit

This block is one stage of a vector execution pipeline. It accepts three 128-bit operands: the present contents of the destination register, a source vector and a mask vector. It also takes an immediate rotate amount and an element-size code. The source is cut into equal lanes of 8, 16, 32 or 64 bits. Every lane is rotated left by the same amount, and the rotated bits are written into the destination only where the matching mask bits are one. All other destination bits pass through untouched, so the operation is a read-modify-write of the destination.

An element-size code outside the four legal values is reported through a specification-exception flag, and the old destination comes back unchanged. The result is registered: an operation accepted with `in_valid` appears on `out_vec` with `out_valid` one clock later. Lane 0 occupies the most significant bits. The source and mask lanes are mapped the same way, so lanes line up bit for bit.

Top module: `rim_unit`

## Requirements
- R1: For every lane, the result equals (dest AND NOT mask) OR (rotl(src, k) AND mask). The lane width is 8, 16, 32 or 64 bits for size codes 0, 1, 2 and 3, which gives 16, 8, 4 or 2 lanes in the 128-bit vector.
- R2: The rotate is confined to its lane. A bit leaving the top of a lane comes back at the bottom of the same lane, and no bit moves into a neighbouring lane.
- R3: The effective rotate amount k is the 8-bit immediate taken modulo the lane width, so only its low 3, 4, 5 or 6 bits matter.
- R4: A size code of 4 or more, in the 4-bit size input, sets `out_spec_exc` to 1 with the result, and `out_vec` then equals the destination operand unchanged.
- R5: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1. The result of that accepted operation is on `out_vec` in the same cycle.
- R6: A synchronous active-high reset clears `out_valid`, `out_vec` and `out_spec_exc` to zero at the next clock edge.
- R7: An all-zero mask yields the destination operand unchanged, whatever the source and amount.
- R8: An all-ones mask with a legal size yields exactly the lane-rotated source. With a rotate amount of zero, the source appears unrotated.
- R9: While `in_valid` is 0, `out_vec` and `out_spec_exc` keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_dest | input | 128 | Current destination register value |
| in_src | input | 128 | Vector whose lanes are rotated |
| in_mask | input | 128 | Per-bit insert mask |
| in_amount | input | 8 | Immediate rotate amount |
| in_size | input | 4 | Element-size code, 0 to 3 legal |
| out_valid | output | 1 | Result valid |
| out_vec | output | 128 | Merged destination value |
| out_spec_exc | output | 1 | Illegal size code was given |

## Verification
Lane containment is the hardest property to expose, because a random mask hides most crossing errors. To make it visible, directed cases place a single set bit at the top of every lane and use an all-ones mask, so a wrong wrap shows up in the neighbouring lane. The amount reduction is driven with immediates whose upper bits are set, such as 17, 37, 70 and 255. The illegal-size path uses codes 5 and 15, placed between legal operations so the flag can be seen both rising and clearing.

// File: rtl/rim_pkg.sv
package rim_pkg;
   localparam int RIM_VEC_W    = 128;
   localparam int RIM_AMT_W    = 8;
   localparam int RIM_SIZE_W   = 4;
   localparam int RIM_N_SIZES  = 4;
   localparam int RIM_MIN_LANE = 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } rim_size_e;

   function automatic int rim_lane_width(input int code);
      return RIM_MIN_LANE << code;
   endfunction
endpackage

// File: rtl/rim_lane_rot.sv
module rim_lane_rot #(
   parameter int LANE_W = 8,
   localparam int SH_W  = $clog2(LANE_W)
) (
   input  logic [LANE_W-1:0] lane_in,
   input  logic [SH_W-1:0]   sh,
   output logic [LANE_W-1:0] lane_out
);
   logic [2*LANE_W-1:0] doubled;

   generate
      if ((1 << SH_W) != LANE_W) begin : g_bad_width
         $error("rim_lane_rot: LANE_W must be a power of two");
      end
   endgenerate

   always_comb begin
      doubled  = {lane_in, lane_in} << sh;
      lane_out = doubled[2*LANE_W-1:LANE_W];
   end

   // R2: a rotation keeps every bit inside the lane
   always_comb begin
      assert_rot_keeps_bits_R2: assert ($countones(lane_out) == $countones(lane_in))
         else $error("lane rotation changed the bit count");
   end
endmodule

// File: rtl/rim_size_slice.sv
module rim_size_slice #(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 8,
   parameter int AMT_W  = 8,
   localparam int N_LANES = VEC_W / LANE_W,
   localparam int SH_W    = $clog2(LANE_W)
) (
   input  logic [VEC_W-1:0] dest,
   input  logic [VEC_W-1:0] src,
   input  logic [VEC_W-1:0] mask,
   input  logic [AMT_W-1:0] amount,
   output logic [VEC_W-1:0] merged
);
   logic [SH_W-1:0]  sh_eff;
   logic [VEC_W-1:0] rotated;

   generate
      if (VEC_W % LANE_W != 0) begin : g_bad_split
         $error("rim_size_slice: VEC_W must be a multiple of LANE_W");
      end
   endgenerate

   // R3: amount taken modulo the lane width
   assign sh_eff = SH_W'(amount % AMT_W'(LANE_W));

   // lane 0 at the top of the vector; all operands use the same mapping
   for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
      localparam int HI = VEC_W - 1 - ln * LANE_W;
      rim_lane_rot #(.LANE_W(LANE_W)) u_rot (
         .lane_in  (src[HI -: LANE_W]),
         .sh       (sh_eff),
         .lane_out (rotated[HI -: LANE_W])
      );
   end

   assign merged = (dest & ~mask) | (rotated & mask);

   always_comb begin
      if (&mask) begin
         assert_full_mask_R8: assert (merged == rotated)
            else $error("full mask did not yield rotated source");
      end
      if (mask == '0) begin
         assert_empty_mask_R7: assert (merged == dest)
            else $error("empty mask altered destination");
      end
   end
endmodule

// File: rtl/rim_size_mux.sv
module rim_size_mux #(
   parameter int VEC_W   = 128,
   parameter int SIZE_W  = 4,
   parameter int N_SIZES = 4
) (
   input  logic [VEC_W-1:0]  slices [N_SIZES],
   input  logic [VEC_W-1:0]  dest,
   input  logic [SIZE_W-1:0] size,
   output logic [VEC_W-1:0]  result,
   output logic              spec_exc
);
   logic [N_SIZES-1:0] hit;

   always_comb begin
      for (int k = 0; k < N_SIZES; k++) hit[k] = (size == SIZE_W'(k));
   end

   always_comb begin
      result   = dest;
      spec_exc = 1'b1;
      for (int k = 0; k < N_SIZES; k++) begin
         if (hit[k]) begin
            result   = slices[k];
            spec_exc = 1'b0;
         end
      end
   end

   always_comb begin
      assert_single_size_R1: assert ($onehot0(hit))
         else $error("more than one size selected");
      if (spec_exc) begin
         assert_exc_keeps_dest_R4: assert (result == dest)
            else $error("illegal size altered destination");
      end
   end
endmodule

// File: rtl/rim_unit.sv
module rim_unit
   import rim_pkg::*;
#(
   parameter int VEC_W  = RIM_VEC_W,
   parameter int AMT_W  = RIM_AMT_W,
   parameter int SIZE_W = RIM_SIZE_W,
   localparam int N_SIZES = RIM_N_SIZES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  in_dest,
   input  logic [VEC_W-1:0]  in_src,
   input  logic [VEC_W-1:0]  in_mask,
   input  logic [AMT_W-1:0]  in_amount,
   input  logic [SIZE_W-1:0] in_size,
   output logic              out_valid,
   output logic [VEC_W-1:0]  out_vec,
   output logic              out_spec_exc
);
   logic [VEC_W-1:0] slice_res [N_SIZES];
   logic [VEC_W-1:0] comb_res;
   logic             comb_exc;

   generate
      if (VEC_W % (RIM_MIN_LANE << (N_SIZES - 1)) != 0) begin : g_bad_vec
         $error("rim_unit: VEC_W must hold whole widest lanes");
      end
      if ((1 << AMT_W) < (RIM_MIN_LANE << (N_SIZES - 1))) begin : g_bad_amt
         $error("rim_unit: AMT_W too narrow for the widest lane");
      end
      if ((1 << SIZE_W) < N_SIZES) begin : g_bad_size
         $error("rim_unit: SIZE_W too narrow");
      end
   endgenerate

   for (genvar s = 0; s < N_SIZES; s++) begin : g_size
      rim_size_slice #(
         .VEC_W  (VEC_W),
         .LANE_W (RIM_MIN_LANE << s),
         .AMT_W  (AMT_W)
      ) u_slice (
         .dest   (in_dest),
         .src    (in_src),
         .mask   (in_mask),
         .amount (in_amount),
         .merged (slice_res[s])
      );
   end

   rim_size_mux #(
      .VEC_W   (VEC_W),
      .SIZE_W  (SIZE_W),
      .N_SIZES (N_SIZES)
   ) u_mux (
      .slices   (slice_res),
      .dest     (in_dest),
      .size     (in_size),
      .result   (comb_res),
      .spec_exc (comb_exc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         out_vec      <= '0;
         out_spec_exc <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_vec      <= comb_res;
            out_spec_exc <= comb_exc;
         end
      end
   end

   assert_reset_clears_R6: assert property (@(posedge clk)
      rst |=> (!out_valid && out_vec == '0 && !out_spec_exc));

   assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_illegal_size_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_size >= SIZE_W'(N_SIZES))
      |=> (out_spec_exc && out_vec == $past(in_dest)));

   assert_empty_mask_kept_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mask == '0) |=> (out_vec == $past(in_dest)));

   assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_vec) && $stable(out_spec_exc)));
endmodule

// File: tb/tb_rim_unit.sv
module tb_rim_unit;
   localparam int CLK_PERIOD = 10;
   localparam int N_TBL = 8;

   typedef struct packed {
      logic [3:0]   sz;
      logic [7:0]   amt;
      logic [127:0] d;
      logic [127:0] s;
      logic [127:0] m;
   } vec_t;

   localparam vec_t TBL [N_TBL] = '{
      '{4'd0, 8'd3,   128'h0123456789ABCDEF_FEDCBA9876543210, 128'hA5C3_1E7F_0091_B24D_6E58_F0CC_3377_9A1B, 128'hFF00_F0F0_CCCC_AAAA_0F0F_3C3C_5555_00FF},
      '{4'd1, 8'd17,  128'h1111_2222_3333_4444_5555_6666_7777_8888, 128'h8001_4002_2004_1008_0810_0420_0240_0180, 128'hFFFF_0000_FFFF_00FF_FF00_F00F_0FF0_FFFF},
      '{4'd2, 8'd37,  128'hDEADBEEF_CAFEF00D_0BADC0DE_FEEDFACE, 128'h80000001_12345678_F0000000_00000003, 128'hFFFFFFFF_0000FFFF_FFFF0000_F0F0F0F0},
      '{4'd3, 8'd70,  128'h0F0F0F0F0F0F0F0F_F0F0F0F0F0F0F0F0, 128'hFC00000000000003_0123456789ABCDEF, 128'hFFFFFFFFFFFFFFFF_00000000FFFFFFFF},
      '{4'd3, 8'd0,   128'h5555555555555555_AAAAAAAAAAAAAAAA, 128'h13579BDF02468ACE_FFEEDDCCBBAA9988, {128{1'b1}}},
      '{4'd0, 8'd255, 128'hC0FFEE00_12345678_9ABCDEF0_0F1E2D3C, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'h0},
      '{4'd2, 8'd31,  128'h0, 128'h00000001_80000000_DEADBEEF_00010000, {128{1'b1}}},
      '{4'd1, 8'd8,   128'hFFFF_FFFF_0000_0000_FFFF_0000_FFFF_0000, 128'h12AB_34CD_56EF_7801_9A23_BC45_DE67_F089, 128'h0FF0_F00F_FFFF_0000_00FF_FF00_AAAA_5555}
   };

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [127:0] in_dest, in_src, in_mask;
   logic [7:0]   in_amount;
   logic [3:0]   in_size;
   logic         out_valid;
   logic [127:0] out_vec;
   logic         out_spec_exc;

   int checks = 0;
   int errors = 0;

   rim_unit dut (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_dest      (in_dest),
      .in_src       (in_src),
      .in_mask      (in_mask),
      .in_amount    (in_amount),
      .in_size      (in_size),
      .out_valid    (out_valid),
      .out_vec      (out_vec),
      .out_spec_exc (out_spec_exc)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // bitwise reference: out bit j of a lane takes source bit (j - k) mod w
   function automatic logic [127:0] model(input int sz, input int amt,
      input logic [127:0] d, input logic [127:0] s, input logic [127:0] m);
      logic [127:0] r;
      int w, k, base, j, from;
      w = 8 << sz;
      k = amt % w;
      for (int b = 0; b < 128; b++) begin
         base = (b / w) * w;
         j    = b - base;
         from = (j - k + w) % w;
         r[b] = m[b] ? s[base + from] : d[b];
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] sz, input logic [7:0] amt,
      input logic [127:0] d, input logic [127:0] s, input logic [127:0] m);
      in_valid  = 1'b1;
      in_size   = sz;
      in_amount = amt;
      in_dest   = d;
      in_src    = s;
      in_mask   = m;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [127:0] held;
      rst = 1'b1;
      drive(4'd0, 8'd1, {128{1'b1}}, {128{1'b1}}, {128{1'b1}});
      repeat (3) @(negedge clk);
      // R6: reset state, even with in_valid high
      chk("R6 reset out_valid", {127'd0, out_valid}, 128'd0);
      chk("R6 reset out_vec", out_vec, 128'd0);
      chk("R6 reset exc", {127'd0, out_spec_exc}, 128'd0);
      rst = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);

      // R1 R3 R7 R8: table walk
      for (int i = 0; i < N_TBL; i++) begin
         drive(TBL[i].sz, TBL[i].amt, TBL[i].d, TBL[i].s, TBL[i].m);
         @(negedge clk);
         in_valid = 1'b0;
         chk("R5 valid after accept", {127'd0, out_valid}, 128'd1);
         chk("R1 R3 merged result", out_vec,
             model(int'(TBL[i].sz), int'(TBL[i].amt), TBL[i].d, TBL[i].s, TBL[i].m));
         chk("R1 no exception", {127'd0, out_spec_exc}, 128'd0);
         if (i == 4) chk("R8 full mask zero amount", out_vec, TBL[i].s);
         if (i == 5) chk("R7 empty mask", out_vec, TBL[i].d);
      end

      // R2: top bit of every byte lane wraps to bit 0 of the same lane
      drive(4'd0, 8'd1, 128'h0, {16{8'h80}}, {128{1'b1}});
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 byte lane wrap", out_vec, {16{8'h01}});

      // R2: top nibble of each 64-bit lane wraps to the bottom
      drive(4'd3, 8'd4, 128'h0, {2{64'hF000000000000000}}, {128{1'b1}});
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 dword lane wrap", out_vec, {2{64'h000000000000000F}});

      // R3: amount 9 on byte lanes acts as 1
      drive(4'd0, 8'd9, 128'h0, {16{8'h81}}, {128{1'b1}});
      @(negedge clk);
      in_valid = 1'b0;
      chk("R3 byte amount modulo", out_vec, {16{8'h03}});

      // R4: illegal size codes
      drive(4'd5, 8'd3, 128'hCAFE_0000_1111_2222_3333_4444_5555_BEEF, {128{1'b1}}, {128{1'b1}});
      @(negedge clk);
      chk("R4 exc size 5", {127'd0, out_spec_exc}, 128'd1);
      chk("R4 dest kept size 5", out_vec, 128'hCAFE_0000_1111_2222_3333_4444_5555_BEEF);
      drive(4'd15, 8'd0, 128'h0123, 128'h0, {128{1'b1}});
      @(negedge clk);
      in_valid = 1'b0;
      chk("R4 exc size 15", {127'd0, out_spec_exc}, 128'd1);
      chk("R4 dest kept size 15", out_vec, 128'h0123);

      // R9 R5: idle cycles hold result and drop valid
      held = out_vec;
      @(negedge clk);
      chk("R5 valid drops when idle", {127'd0, out_valid}, 128'd0);
      chk("R9 result held", out_vec, held);
      chk("R9 exc held", {127'd0, out_spec_exc}, 128'd1);

      // R5: back-to-back operations, exception clears on a legal op
      drive(4'd1, 8'd4, 128'h0, {8{16'h1234}}, {128{1'b1}});
      @(negedge clk);
      chk("R5 first of pair", out_vec, {8{16'h2341}});
      chk("R4 exc clears", {127'd0, out_spec_exc}, 128'd0);
      drive(4'd2, 8'd8, 128'h0, {4{32'hAABBCCDD}}, {128{1'b1}});
      @(negedge clk);
      in_valid = 1'b0;
      chk("R5 second of pair", out_vec, {4{32'hBBCCDDAA}});
      chk("R5 valid on second", {127'd0, out_valid}, 128'd1);

      // R6: reset in mid-run
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R6 mid-run reset vec", out_vec, 128'd0);
      chk("R6 mid-run reset valid", {127'd0, out_valid}, 128'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule